// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block is the digital front end that sits behind an on-chip voltage comparator. The comparator output arrives asynchronously. It passes through a synchronizer, and an edge detector then compares each new sample with the one before it. A 2-bit mode field selects the kind of transition that counts as an event. An event sets a sticky interrupt flag. The interrupt line is raised only while the local enable and the CPU's global interrupt enable are both set.

A capture-steering bit can route the synchronized comparator level into a timer's input-capture path. On that path a noise canceler requires several agreeing samples before the level changes. A separate pin-disable register forces the readback of the two comparator input pins to zero.

Software reaches the block through a byte-wide register port. Writes are synchronous. Reads are combinational from the read address.

Top module: `cmp_evt_irq`

## Requirements
- R1: After reset, every control bit, the flag, both pin-disable bits, `irq`, `cap_route` and `cap_irq` are 0, and every register reads 0 while the comparator input is low.
- R2: The control register is at address 0, with these bits: [0] local enable, [1] capture steering, [3:2] mode, [4] flag (writing 1 clears it), [5] synchronized comparator level (read only). Bits [7:6] read 0. In mode 00, both a rising and a falling comparator transition set the flag. The flag, and `irq` when it is enabled, appear three clock edges after the edge that first samples the new input level.
- R3: In mode 10 only a falling transition sets the flag. In mode 11 only a rising transition sets it.
- R4: Mode 01 is reserved and never sets the flag.
- R5: `irq` is high exactly when the flag, the local enable and `glb_ie` are all 1. Changing `glb_ie` takes effect in the same cycle.
- R6: The flag stays set until a control write has bit 4 set or `irq_ack` is pulsed. If a set event and a clear arrive in the same cycle, the set wins.
- R7: In modes 10 and 11, the detector compares a mode-dependent polarity of the level. Switching between these modes while the comparator is high therefore sets the flag, and raises `irq` one cycle after the write when the local enable is on. If the local enable is cleared before the change, and the flag is cleared before the enable is set again, `irq` stays low.
- R8: While capture steering is 0, `cap_route` is 0 from the cycle after the bit is seen as 0, and `cap_irq` stays 0.
- R9: While capture steering is 1, `cap_route` takes a new level only after 4 consecutive synchronized samples that differ from it. A run of 3 is rejected.
- R10: `cap_irq` pulses for one cycle, in the same cycle that `cap_route` changes, when the new level equals `cap_edge_sel` (1 means rising, 0 means falling) and `cap_mask` is 1.
- R11: The pin-disable register is at address 1. Bits [1:0] are read/write, one bit per comparator pin. Bits [7:2] always read 0.
- R12: Address 2 returns the pin levels: bit i equals `pin_in[i]` AND NOT disable bit i. Bits [7:2] read 0, and so does every bit of address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Asynchronous comparator output |
| glb_ie | input | 1 | CPU global interrupt enable |
| irq_ack | input | 1 | Pulse that clears the flag when the interrupt is serviced |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| pin_in | input | 2 | Digital levels of the two comparator input pins |
| cap_edge_sel | input | 1 | Timer capture edge select: 1 rising, 0 falling |
| cap_mask | input | 1 | Timer capture interrupt mask |
| irq | output | 1 | Comparator interrupt request |
| cap_route | output | 1 | Noise-filtered comparator level steered to the timer |
| cap_irq | output | 1 | Timer capture interrupt caused by the comparator |

## Verification
Take the edge that first samples a comparator change as edge 1. The flag and `irq` follow on edge 3. The steered level and `cap_irq` follow on edge 6: two synchronizer edges and four filter samples. A register write lands on the next edge. A mode-switch glitch shows on `irq` one edge after the write, while `glb_ie` and read data act within the cycle. The bench drives inputs just after a rising edge. Each stimulus queues its expected values tagged with the cycle in which they are due. A monitor at the falling edge compares only the items due in that cycle, so every result is checked in exactly one cycle, and the cycles before it are checked as well where the timing matters.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
    localparam int REG_AW = 2;
    localparam int REG_DW = 8;
    localparam int N_PINS = 2;

    localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_DIS  = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_PIN  = 2'd2;

    localparam int BIT_IE     = 0;
    localparam int BIT_CAPEN  = 1;
    localparam int BIT_MODE_L = 2;
    localparam int BIT_FLAG   = 4;

    typedef enum logic [1:0] {
        MODE_TOGGLE = 2'b00,
        MODE_RSVD   = 2'b01,
        MODE_FALL   = 2'b10,
        MODE_RISE   = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic              ie;
        logic              cap_en;
        edge_mode_e        mode;
        logic              flag;
        logic [N_PINS-1:0] dis;
    } ctrl_state_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
    import cmp_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  edge_mode_e mode,
    output logic       evt
);
    typedef struct packed {
        logic lvl_prev;
        logic pol_prev;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       pol;

    always_comb begin
        // polarity follows the current mode, so a mode switch can look like an edge
        pol         = mode[0] ? lvl : ~lvl;
        st_d        = st_q;
        st_d.lvl_prev = lvl;
        st_d.pol_prev = pol;
        unique case (mode)
            MODE_TOGGLE: evt = lvl ^ st_q.lvl_prev;
            MODE_RSVD:   evt = 1'b0;
            default:     evt = pol & ~st_q.pol_prev;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cmp_cap_filter.sv
module cmp_cap_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lvl,
    input  logic edge_sel,
    input  logic mask,
    output logic route,
    output logic cap_irq
);
    localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          filt;
        logic          evt;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        if (!en) begin
            st_d.filt = 1'b0;
            st_d.cnt  = '0;
        end else if (lvl == st_q.filt) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.filt = lvl;
            st_d.cnt  = '0;
            st_d.evt  = (lvl == edge_sel);
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign route   = st_q.filt;
    assign cap_irq = st_q.evt & mask;
endmodule

// File: rtl/cmp_evt_irq.sv
module cmp_evt_irq
    import cmp_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_raw,
    input  logic              glb_ie,
    input  logic              irq_ack,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [REG_DW-1:0] rd_data,
    input  logic [N_PINS-1:0] pin_in,
    input  logic              cap_edge_sel,
    input  logic              cap_mask,
    output logic              irq,
    output logic              cap_route,
    output logic              cap_irq
);
    localparam int PAD = REG_DW - N_PINS;

    ctrl_state_t st_d, st_q;
    logic        lvl_s;
    logic        evt;
    logic        ctrl_wr;

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cmp_raw),
        .dout  (lvl_s)
    );

    cmp_edge_det u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl_s),
        .mode  (st_q.mode),
        .evt   (evt)
    );

    cmp_cap_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (st_q.cap_en),
        .lvl      (lvl_s),
        .edge_sel (cap_edge_sel),
        .mask     (cap_mask),
        .route    (cap_route),
        .cap_irq  (cap_irq)
    );

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
        st_d    = st_q;
        if (ctrl_wr) begin
            st_d.ie     = wr_data[BIT_IE];
            st_d.cap_en = wr_data[BIT_CAPEN];
            st_d.mode   = edge_mode_e'(wr_data[BIT_MODE_L +: 2]);
            if (wr_data[BIT_FLAG]) st_d.flag = 1'b0;
        end
        if (irq_ack) st_d.flag = 1'b0;
        if (evt)     st_d.flag = 1'b1;
        if (wr_en && (wr_addr == ADDR_DIS)) st_d.dis = wr_data[N_PINS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL: rd_data = {2'b00, lvl_s, st_q.flag, st_q.mode, st_q.cap_en, st_q.ie};
            ADDR_DIS:  rd_data = {{PAD{1'b0}}, st_q.dis};
            ADDR_PIN:  rd_data = {{PAD{1'b0}}, pin_in & ~st_q.dis};
            default:   rd_data = '0;
        endcase
    end

    assign irq = st_q.flag & st_q.ie & glb_ie;
endmodule

// File: rtl/cmp_evt_irq_chk.sv
module cmp_evt_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       glb_ie,
    input logic       irq_ack,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       wr_clr,
    input logic [1:0] rd_addr,
    input logic [7:0] rd_data,
    input logic       irq,
    input logic       cap_mask,
    input logic       cap_route,
    input logic       cap_irq,
    input logic       cap_en_q,
    input logic [1:0] mode_q,
    input logic       flag_q,
    input logic [1:0] dis_q
);
    AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> glb_ie); // R5
    AST_RSVD_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && mode_q == 2'b01) |=> !flag_q); // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && mode_q == 2'b01) |=> !flag_q); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !irq_ack && !(wr_en && wr_addr == 2'd0 && wr_clr)) |=> flag_q); // R6
    AST_CAP_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_q |=> (!cap_route && !cap_irq)); // R8
    AST_CAP_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq |-> cap_mask); // R10
    AST_DIS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd1) |-> (rd_data[7:2] == 6'd0)); // R11
    AST_PIN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd2) |-> (rd_data[7:2] == 6'd0 && (rd_data[1:0] & dis_q) == 2'b00)); // R12
endmodule

bind cmp_evt_irq cmp_evt_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_ie    (glb_ie),
    .irq_ack   (irq_ack),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_clr    (wr_data[4]),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .irq       (irq),
    .cap_mask  (cap_mask),
    .cap_route (cap_route),
    .cap_irq   (cap_irq),
    .cap_en_q  (st_q.cap_en),
    .mode_q    (st_q.mode),
    .flag_q    (st_q.flag),
    .dis_q     (st_q.dis)
);

// File: tb/cmp_evt_irq_bench.sv
`timescale 1ns/1ps
module cmp_evt_irq_bench;
    localparam int K_IRQ = 0, K_ROUTE = 1, K_CAPIRQ = 2, K_RD = 3;

    typedef struct {
        int         due;
        int         kind;
        logic [7:0] val;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_raw = 1'b0, glb_ie = 1'b1, irq_ack = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0, pin_in = '0;
    logic [7:0] wr_data = '0;
    logic       cap_edge_sel = 1'b1, cap_mask = 1'b1;
    logic [7:0] rd_data;
    logic       irq, cap_route, cap_irq;

    int   cyc = 0;
    int   checks = 0, fails = 0;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmp_evt_irq u_cmp_evt_irq (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .glb_ie(glb_ie), .irq_ack(irq_ack),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pin_in(pin_in), .cap_edge_sel(cap_edge_sel), .cap_mask(cap_mask),
        .irq(irq), .cap_route(cap_route), .cap_irq(cap_irq)
    );

    // monitor: compare every item due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                logic [7:0] act;
                case (sb[i].kind)
                    K_IRQ:    act = {7'd0, irq};
                    K_ROUTE:  act = {7'd0, cap_route};
                    K_CAPIRQ: act = {7'd0, cap_irq};
                    default:  act = rd_data;
                endcase
                checks++;
                if (act !== sb[i].val) begin
                    fails++;
                    $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                             sb[i].req, sb[i].kind, cyc, act, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_n(int n);
        repeat (n) step();
    endtask

    task automatic exp_at(int dly, int kind, logic [7:0] v, string req);
        sb.push_back('{cyc + dly, kind, v, req});
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [1:0] a, logic [7:0] v, string req);
        rd_addr = a;
        exp_at(0, K_RD, v, req);
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        // R1 reset state
        exp_at(0, K_IRQ, 0, "R1");
        exp_at(0, K_ROUTE, 0, "R1");
        exp_at(0, K_CAPIRQ, 0, "R1");
        rd_chk(2'd0, 8'h00, "R1");
        rd_chk(2'd1, 8'h00, "R1");

        // R2 toggle mode, both edges, three-edge latency
        wr(2'd0, 8'h01);
        cmp_raw = 1'b1;
        exp_at(2, K_IRQ, 0, "R2"); exp_at(3, K_IRQ, 1, "R2");
        wait_n(4);
        rd_chk(2'd0, 8'h31, "R2");
        wr(2'd0, 8'h11);
        exp_at(0, K_IRQ, 0, "R6");
        rd_chk(2'd0, 8'h21, "R6");
        cmp_raw = 1'b0;
        exp_at(2, K_IRQ, 0, "R2"); exp_at(3, K_IRQ, 1, "R2");
        wait_n(4);
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        exp_at(0, K_IRQ, 0, "R6");

        // R3 falling-only and rising-only modes
        wr(2'd0, 8'h19);
        rd_chk(2'd0, 8'h09, "R3");
        cmp_raw = 1'b1;
        exp_at(3, K_IRQ, 0, "R3"); exp_at(5, K_IRQ, 0, "R3");
        wait_n(6);
        cmp_raw = 1'b0;
        exp_at(3, K_IRQ, 1, "R3");
        wait_n(4);
        wr(2'd0, 8'h1D);
        exp_at(0, K_IRQ, 0, "R3");
        cmp_raw = 1'b1;
        exp_at(3, K_IRQ, 1, "R3");
        wait_n(4);
        wr(2'd0, 8'h1D);
        cmp_raw = 1'b0;
        exp_at(3, K_IRQ, 0, "R3"); exp_at(5, K_IRQ, 0, "R3");
        wait_n(6);
        rd_chk(2'd0, 8'h0D, "R3");

        // R4 reserved mode
        wr(2'd0, 8'h15);
        cmp_raw = 1'b1;
        exp_at(3, K_IRQ, 0, "R4");
        wait_n(5);
        cmp_raw = 1'b0;
        exp_at(3, K_IRQ, 0, "R4");
        wait_n(5);
        rd_chk(2'd0, 8'h05, "R4");

        // R5 global gate, R6 sticky
        glb_ie = 1'b0;
        wr(2'd0, 8'h11);
        cmp_raw = 1'b1;
        wait_n(4);
        exp_at(0, K_IRQ, 0, "R5");
        rd_chk(2'd0, 8'h31, "R5");
        glb_ie = 1'b1;
        exp_at(0, K_IRQ, 1, "R5");
        step();
        wr(2'd0, 8'h00);
        exp_at(0, K_IRQ, 0, "R5");
        rd_chk(2'd0, 8'h30, "R6");
        wr(2'd0, 8'h10);
        rd_chk(2'd0, 8'h20, "R6");

        // R7 spurious event on mode switch, comparator high
        wr(2'd0, 8'h19);
        exp_at(1, K_IRQ, 0, "R7");
        step();
        wr(2'd0, 8'h0D);
        exp_at(0, K_IRQ, 0, "R7"); exp_at(1, K_IRQ, 1, "R7");
        wait_n(2);
        wr(2'd0, 8'h18);
        rd_chk(2'd0, 8'h28, "R7");
        wr(2'd0, 8'h0C);
        step();
        exp_at(0, K_IRQ, 0, "R7");
        rd_chk(2'd0, 8'h3C, "R7");
        wr(2'd0, 8'h1C);
        rd_chk(2'd0, 8'h2C, "R7");
        wr(2'd0, 8'h0D);
        exp_at(0, K_IRQ, 0, "R7"); exp_at(1, K_IRQ, 0, "R7"); exp_at(2, K_IRQ, 0, "R7");
        wait_n(3);
        wr(2'd0, 8'h10);

        // R8..R10 capture steering and noise canceler
        exp_at(0, K_ROUTE, 0, "R8");
        wr(2'd0, 8'h02);
        exp_at(3, K_ROUTE, 0, "R9"); exp_at(4, K_ROUTE, 1, "R9");
        exp_at(3, K_CAPIRQ, 0, "R10"); exp_at(4, K_CAPIRQ, 1, "R10"); exp_at(5, K_CAPIRQ, 0, "R10");
        wait_n(6);
        cmp_raw = 1'b0;
        wait_n(3);
        cmp_raw = 1'b1;
        for (int d = 0; d < 8; d++) exp_at(d, K_ROUTE, 1, "R9");
        wait_n(8);
        cmp_raw = 1'b0;
        exp_at(5, K_ROUTE, 1, "R9"); exp_at(6, K_ROUTE, 0, "R9");
        exp_at(6, K_CAPIRQ, 0, "R10");
        wait_n(8);
        cap_edge_sel = 1'b0; cap_mask = 1'b0;
        cmp_raw = 1'b1;
        exp_at(6, K_ROUTE, 1, "R9"); exp_at(6, K_CAPIRQ, 0, "R10");
        wait_n(8);
        cap_mask = 1'b1;
        cmp_raw = 1'b0;
        exp_at(6, K_ROUTE, 0, "R9"); exp_at(6, K_CAPIRQ, 1, "R10");
        wait_n(8);
        cmp_raw = 1'b1;
        wait_n(8);
        wr(2'd0, 8'h00);
        exp_at(0, K_ROUTE, 1, "R8"); exp_at(1, K_ROUTE, 0, "R8");
        wait_n(2);
        cmp_raw = 1'b0;
        exp_at(6, K_ROUTE, 0, "R8"); exp_at(6, K_CAPIRQ, 0, "R8");
        wait_n(8);

        // R11, R12 pin-disable register and readback
        wr(2'd1, 8'hFF);
        rd_chk(2'd1, 8'h03, "R11");
        pin_in = 2'b11;
        rd_chk(2'd2, 8'h00, "R12");
        wr(2'd1, 8'h01);
        rd_chk(2'd2, 8'h02, "R12");
        wr(2'd1, 8'h00);
        rd_chk(2'd2, 8'h03, "R12");
        rd_chk(2'd1, 8'h00, "R11");
        pin_in = 2'b01;
        rd_chk(2'd2, 8'h01, "R12");
        rd_chk(2'd3, 8'h00, "R12");

        wait_n(10);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL pending actual=%0d expected=0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule